// File: doc/BRIEF.md
# Dual-Style Host Bus Slave Port

This block lets a byte-wide host processor read and write an internal register file. The host side is a set of asynchronous bus pins: a chip select, an address strobe, two shared control lines, a 12-bit address input and an 8-bit data bus. The data bus is carried as separate in, out and output-enable signals. The register side is a 12-bit address, one-clock read and write enables, write data and read data returned combinationally from the register file.

Three static pins configure the port, and each is expected to change only while the block is in reset. `styleSel` picks how the two control lines are read. Low selects a single read/write level qualified by a data strobe. High selects separate active-low read and write strobes. `muxAddr` chooses between two address sources. When low, the address comes from the dedicated address input. When high, the low address byte is taken from the shared bus and the upper bits from the address input. `syncMode` states whether `clk` is the host's own bus clock or an unrelated internal clock. With the host clock, each control input is sampled through one flip-flop. With an internal clock, each passes through a two-flip-flop synchronizer.

A write is committed once, when its strobe is released, using the last data seen on the bus. A read raises a one-clock enable when it begins. The read data is presented on the bus only while the host is actively reading the selected port.

Top module: `hostBusPort`

## Requirements
- R1: While reset is held and on the first cycle after it, `regWrEn`, `regRdEn` and `adOe` are all 0.
- R2: With `muxAddr`=0, the 12-bit `regAddr` of an access equals the `addrIn` value the host held while asserting the strobe.
- R3: With `muxAddr`=1, `regAddr[7:0]` is the `adIn` byte present when `addrStb` falls (high to low), `regAddr[11:8]` is `addrIn[11:8]`, and `addrIn[7:0]` has no effect.
- R4: With `styleSel`=0, an access runs while `csN`=0 and `dsRdN`=0. `rwWrN`=1 makes it a read and `rwWrN`=0 makes it a write.
- R5: With `styleSel`=1, `csN`=0 together with `dsRdN`=0 is a read, and `csN`=0 together with `rwWrN`=0 is a write.
- R6: Each write access gives exactly one `regWrEn` pulse of one clock. It follows the release of the write strobe, and `regWrData` equals the last `adIn` byte seen while the strobe was active.
- R7: Each read access gives exactly one `regRdEn` pulse of one clock, with `regAddr` set to the access address. While the read is in progress, `adOut` equals `regRdData`.
- R8: `adOe` is 1 only while `csN`=0 and the read condition holds on the raw pins. It returns to 0 in the same cycle that the read strobe is released.
- R9: With `syncMode`=1, `regRdEn` appears after the first rising clock edge that follows assertion of the read strobe. With `syncMode`=0, it appears after the second such edge.
- R10: Toggling the strobes while `csN`=1 produces no `regWrEn`, no `regRdEn` and no `adOe`.
- R11: A change on `addrIn` after the strobe has been taken in does not alter the address of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the host bus clock when `syncMode`=1 |
| rstN | input | 1 | Asynchronous active-low reset |
| styleSel | input | 1 | 0: read/write level plus data strobe; 1: separate read and write strobes |
| muxAddr | input | 1 | 1: low address byte taken from the data bus |
| syncMode | input | 1 | 1: one sampling stage; 0: two-stage synchronizer |
| csN | input | 1 | Chip select, active low |
| addrStb | input | 1 | Address strobe; low byte is captured on its falling edge |
| dsRdN | input | 1 | Data strobe (style 0) or read strobe (style 1), active low |
| rwWrN | input | 1 | Read/write level (style 0) or write strobe (style 1) |
| addrIn | input | 12 | Dedicated address input |
| adIn | input | 8 | Shared bus, input side |
| adOut | output | 8 | Shared bus, output side |
| adOe | output | 1 | Output enable for the shared bus |
| regAddr | output | 12 | Register file address |
| regWrData | output | 8 | Register write data |
| regWrEn | output | 1 | One-clock register write enable |
| regRdEn | output | 1 | One-clock register read enable |
| regRdData | input | 8 | Register read data |

## Verification
On every cycle the assertions check four properties. `adOe` never rises without chip select and an active read strobe. The write and read enables are single-cycle and never coincide. The register address holds steady in the cycle a write commits. The scenarios are needed for everything that depends on what the host meant to do. This covers which byte the address latch took in the multiplexed scheme, whether the committed data and address match the transfer, the latency difference between one and two sampling stages, and that strobes outside chip select leave no trace. The bench sweeps all eight combinations of the static pins, using addresses at both ends of the range and in the middle.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  typedef enum logic {
    STYLE_RW_DS = 1'b0,
    STYLE_RD_WR = 1'b1
  } busStyle_t;

  typedef struct packed {
    logic loadAddr;
    logic capLow;
    logic capData;
    logic wrPulse;
    logic rdPulse;
    logic driveBus;
  } hbpStrobes_t;

endpackage

// File: rtl/hbpSampler.sv
module hbpSampler #(
  parameter int W = 4,
  parameter int ASYNC_STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncMode,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [ASYNC_STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ASYNC_STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < ASYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  generate
    if (ASYNC_STAGES > 1) begin : g_multi
      assign dout = syncMode ? stage[0] : stage[ASYNC_STAGES-1];
    end else begin : g_single
      logic unusedMode;
      assign unusedMode = syncMode;
      assign dout = stage[0];
    end
  endgenerate

endmodule

// File: rtl/hbpCtrl.sv
module hbpCtrl
  import hbp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        styleSel,
  input  logic        muxAddr,
  input  logic        syncMode,
  input  logic        csN,
  input  logic        addrStb,
  input  logic        dsRdN,
  input  logic        rwWrN,
  output hbpStrobes_t strobes
);

  logic [3:0] sCtl;
  logic sCs, sAs, sDs, sRw;

  hbpSampler #(.W(4), .ASYNC_STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) ctlSync (
    .clk(clk), .rstN(rstN), .syncMode(syncMode),
    .din({csN, addrStb, dsRdN, rwWrN}), .dout(sCtl)
  );

  assign {sCs, sAs, sDs, sRw} = sCtl;

  busStyle_t style;
  assign style = busStyle_t'(styleSel);

  logic rdNow, wrNow, accNow, rawRd;
  logic rdPrev, wrPrev, asPrev;

  // decode of the sampled controls, and of the raw pins for the bus driver
  always_comb begin
    if (style == STYLE_RW_DS) begin
      rdNow = !sCs && !sDs && sRw;
      wrNow = !sCs && !sDs && !sRw;
      rawRd = !csN && !dsRdN && rwWrN;
    end else begin
      rdNow = !sCs && !sDs;
      wrNow = !sCs && !sRw;
      rawRd = !csN && !dsRdN;
    end
    accNow = rdNow || wrNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
      asPrev <= 1'b1;
    end else begin
      rdPrev <= rdNow;
      wrPrev <= wrNow;
      asPrev <= sAs;
    end
  end

  always_comb begin
    strobes.loadAddr = !accNow;
    strobes.capLow   = muxAddr && asPrev && !sAs;
    strobes.capData  = wrNow;
    strobes.wrPulse  = wrPrev && !wrNow;
    strobes.rdPulse  = rdNow && !rdPrev;
    strobes.driveBus = rdNow && rawRd;
  end

endmodule

// File: rtl/hbpDatapath.sv
module hbpDatapath
  import hbp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMode,
  input  logic              muxAddr,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] adIn,
  input  hbpStrobes_t       strobes,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int SMP_W = ADDR_W + DATA_W;

  logic [SMP_W-1:0]  sBus;
  logic [ADDR_W-1:0] sAddr;
  logic [DATA_W-1:0] sAd;

  // address and data pass the same number of stages as the controls
  hbpSampler #(.W(SMP_W), .ASYNC_STAGES(SYNC_STAGES), .RST_VAL('0)) busSync (
    .clk(clk), .rstN(rstN), .syncMode(syncMode),
    .din({addrIn, adIn}), .dout(sBus)
  );

  assign {sAddr, sAd} = sBus;

  logic [HI_W-1:0]   hiReg;
  logic [DATA_W-1:0] loReg;
  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg   <= '0;
      loReg   <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.loadAddr) hiReg <= sAddr[ADDR_W-1:DATA_W];
      if (muxAddr) begin
        if (strobes.capLow) loReg <= sAd;
      end else if (strobes.loadAddr) begin
        loReg <= sAddr[DATA_W-1:0];
      end
      if (strobes.capData) dataReg <= sAd;
    end
  end

  assign regAddr   = {hiReg, loReg};
  assign regWrData = dataReg;
  assign regWrEn   = strobes.wrPulse;
  assign regRdEn   = strobes.rdPulse;
  assign adOut     = regRdData;
  assign adOe      = strobes.driveBus;

endmodule

// File: rtl/hostBusPort.sv
module hostBusPort
  import hbp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              styleSel,
  input  logic              muxAddr,
  input  logic              syncMode,
  input  logic              csN,
  input  logic              addrStb,
  input  logic              dsRdN,
  input  logic              rwWrN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);

  hbpStrobes_t strobes;

  hbpCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .styleSel(styleSel), .muxAddr(muxAddr),
    .syncMode(syncMode), .csN(csN), .addrStb(addrStb), .dsRdN(dsRdN),
    .rwWrN(rwWrN), .strobes(strobes)
  );

  hbpDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .syncMode(syncMode), .muxAddr(muxAddr),
    .addrIn(addrIn), .adIn(adIn), .strobes(strobes), .regRdData(regRdData),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .adOut(adOut), .adOe(adOe)
  );

endmodule

// File: rtl/hbpChecker.sv
module hbpChecker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              dsRdN,
  input logic              adOe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic              regRdEn
);

  // R8
  oe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN) adOe |-> !csN);

  // R8
  oe_needs_rdstb_chk: assert property (@(posedge clk) disable iff (!rstN) adOe |-> !dsRdN);

  // R6
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN) regWrEn |=> !regWrEn);

  // R7
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN) regRdEn |=> !regRdEn);

  // R11
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN) regWrEn |-> $stable(regAddr));

  // R6
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(regWrEn && regRdEn));

endmodule

bind hostBusPort hbpChecker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .dsRdN(dsRdN), .adOe(adOe),
  .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn)
);

// File: tb/hostBusPort_tb.sv
`timescale 1ns/1ps
module hostBusPort_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic styleSel = 1'b0, muxAddr = 1'b0, syncMode = 1'b0;
  logic csN = 1'b1, addrStb = 1'b1, dsRdN = 1'b1, rwWrN = 1'b1;
  logic [11:0] addrIn = '0;
  logic [7:0]  adIn = '0;
  logic [7:0]  adOut, regWrData, regRdData;
  logic [11:0] regAddr;
  logic        adOe, regWrEn, regRdEn;

  int testCnt = 0, failCnt = 0;
  int wrCnt = 0, rdCnt = 0;
  logic [11:0] lastWrAddr = '0, lastRdAddr = '0;
  logic [7:0]  lastWrData = '0;
  bit done = 0;

  always #10 clk = ~clk;

  hostBusPort dut_i (
    .clk(clk), .rstN(rstN), .styleSel(styleSel), .muxAddr(muxAddr),
    .syncMode(syncMode), .csN(csN), .addrStb(addrStb), .dsRdN(dsRdN),
    .rwWrN(rwWrN), .addrIn(addrIn), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  function automatic logic [7:0] rdModel(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  assign regRdData = rdModel(regAddr);

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin wrCnt++; lastWrAddr = regAddr; lastWrData = regWrData; end
      if (regRdEn) begin rdCnt++; lastRdAddr = regAddr; end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h (style=%0d mux=%0d sync=%0d)",
               req, act, exp, styleSel, muxAddr, syncMode);
    end
  endtask

  task automatic idlePins();
    csN = 1'b1; dsRdN = 1'b1; rwWrN = 1'b1;
    addrStb = styleSel ? 1'b0 : 1'b1;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    idlePins();
    repeat (3) @(negedge clk);
    check(!regWrEn && !regRdEn && !adOe, "R1", {regWrEn, regRdEn, adOe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!regWrEn && !regRdEn && !adOe, "R1", {regWrEn, regRdEn, adOe}, 0);
    repeat (4) @(negedge clk);
  endtask

  // address phase common to reads and writes; leaves csN low
  task automatic addrPhase(input logic [11:0] a, input logic isWrite);
    addrIn = muxAddr ? {a[11:8], ~a[7:0]} : a;
    adIn   = muxAddr ? a[7:0] : 8'h00;
    csN = 1'b0;
    if (!styleSel) rwWrN = isWrite ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    if (muxAddr) begin
      if (!styleSel) addrStb = 1'b0;
      else begin
        addrStb = 1'b1;
        repeat (2) @(negedge clk);
        addrStb = 1'b0;
      end
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [7:0] d, input bit moveAddr);
    int w0;
    @(negedge clk);
    w0 = wrCnt;
    addrPhase(a, 1'b1);
    adIn = d ^ 8'hFF;
    @(negedge clk);
    if (!styleSel) dsRdN = 1'b0; else rwWrN = 1'b0;
    repeat (2) @(negedge clk);
    adIn = d;
    repeat (2) @(negedge clk);
    if (moveAddr) addrIn = ~addrIn;
    repeat (3) @(negedge clk);
    check(wrCnt == w0, "R6", wrCnt - w0, 0);
    if (!styleSel) dsRdN = 1'b1; else rwWrN = 1'b1;
    repeat (2) @(negedge clk);
    idlePins();
    adIn = 8'h00;
    repeat (5) @(negedge clk);
    check(wrCnt == w0 + 1, styleSel ? "R5" : "R4", wrCnt - w0, 1);
    check(lastWrData == d, "R6", lastWrData, d);
    if (moveAddr)      check(lastWrAddr == a, "R11", lastWrAddr, a);
    else if (muxAddr)  check(lastWrAddr == a, "R3", lastWrAddr, a);
    else               check(lastWrAddr == a, "R2", lastWrAddr, a);
  endtask

  task automatic hostRead(input logic [11:0] a);
    int r0;
    int lat;
    @(negedge clk);
    r0 = rdCnt;
    lat = 0;
    addrPhase(a, 1'b0);
    adIn = 8'h00;
    @(negedge clk);
    dsRdN = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (regRdEn && lat == 0) lat = k;
    end
    check(lat == (syncMode ? 1 : 2), "R9", lat, syncMode ? 1 : 2);
    check(adOe == 1'b1, "R8", adOe, 1);
    check(adOut == rdModel(a), "R7", adOut, rdModel(a));
    dsRdN = 1'b1;
    @(negedge clk);
    check(adOe == 1'b0, "R8", adOe, 0);
    idlePins();
    repeat (5) @(negedge clk);
    check(rdCnt == r0 + 1, styleSel ? "R5" : "R4", rdCnt - r0, 1);
    check(lastRdAddr == a, muxAddr ? "R3" : "R2", lastRdAddr, a);
  endtask

  task automatic deselectedToggles();
    int w0, r0;
    bit sawOe;
    w0 = wrCnt; r0 = rdCnt; sawOe = 0;
    @(negedge clk);
    csN = 1'b1;
    for (int m = 0; m < 3; m++) begin
      rwWrN = (m == 1) ? 1'b0 : 1'b1;
      dsRdN = (m == 2) ? 1'b1 : 1'b0;
      if (m == 2) rwWrN = 1'b0;
      repeat (5) begin @(negedge clk); if (adOe) sawOe = 1; end
      dsRdN = 1'b1; rwWrN = 1'b1;
      repeat (4) begin @(negedge clk); if (adOe) sawOe = 1; end
    end
    check(wrCnt == w0 && rdCnt == r0, "R10", (wrCnt - w0) + (rdCnt - r0), 0);
    check(!sawOe, "R10", sawOe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [3];
    addrs[0] = 12'h000; addrs[1] = 12'hFFF; addrs[2] = 12'hA5C;
    for (int cfg = 0; cfg < 8; cfg++) begin
      styleSel = cfg[0];
      muxAddr  = cfg[1];
      syncMode = cfg[2];
      applyReset();
      for (int i = 0; i < 3; i++) begin
        hostWrite(addrs[i], 8'h5A ^ addrs[i][7:0] ^ 8'(cfg), 1'b0);
        hostRead(addrs[i] ^ 12'(cfg * 37));
      end
      if (!muxAddr) hostWrite(12'h3C7, 8'hE1, 1'b1);
      deselectedToggles();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule